// File: doc/BRIEF.md
# Cascaded Serial Chain Host Sequencer

This block is the host side of a chain of N cascaded serial devices. Each device holds a 17-bit shift register, so the chain is 17×N bits long. The sequencer drives the chain's reset-window line (RST), its shift clock (CLK) and its data line (DQ). It can also release DQ so that the last device's cascade output feeds the first device's input.

A write operation loads a 17×N-bit word from a parallel input and shifts it out, least significant bit first. A read operation releases DQ and clocks the chain round by its full length. Each bit that appears on the feedback line is captured into a parallel output. After the full rotation every device holds what it held before, and dropping RST commits those unchanged values.

A single-cycle start request begins an operation. Busy covers the whole operation, and done pulses once at the end. A divider setting, taken at start, sets the length of every CLK phase in system clock cycles.

Top module: `chain_seq`

## Requirements
- R1: Each operation produces exactly 17×N rising CLK edges, and CLK is high only while RST is high.
- R2: RST rises on the clock edge that accepts start. RST rises and falls only while CLK is low, in both the cycle before and the cycle after the change.
- R3: In a write, chain_dq_oe is high for the whole RST window. wr_data bit k is on chain_dq_out at the k-th rising CLK edge, counting from 0, so bit 0 goes first. chain_dq_out changes only while CLK is low. After RST falls, the chain position nearest the output holds wr_data bit 0.
- R4: In a read, chain_dq_oe is low for the whole RST window. rd_data bit k holds the feedback value sampled in the cycle that CLK rises for the k-th time, counting from 0.
- R5: After a read, the contents committed by the chain equal its contents before the read.
- R6: Each phase lasts div_cfg+1 system cycles, using the div_cfg taken at start. This covers RST rise to first CLK rise, every CLK high phase, every CLK low phase, and last CLK fall to RST fall.
- R7: Busy rises on the edge that accepts start and falls together with the rise of done. Done is a one-cycle pulse that appears in the cycle after RST falls.
- R8: A start request while busy is ignored. The operation in progress keeps its mode, data and divider, and no second operation follows.
- R9: After reset, busy, done, chain_rst, chain_clk and chain_dq_oe are low and rd_data is zero. A write leaves rd_data unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start request, one cycle |
| rd_mode | input | 1 | 1 = read (rotate chain), 0 = write |
| div_cfg | input | DIV_W | Phase length minus one, in system cycles |
| wr_data | input | 17×N_DEV | Word to shift out, bit 0 first |
| rd_data | output | 17×N_DEV | Captured chain contents, bit 0 seen first |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| chain_rst | output | 1 | Chain RST line |
| chain_clk | output | 1 | Chain shift clock |
| chain_dq_out | output | 1 | Value driven onto DQ |
| chain_dq_oe | output | 1 | DQ drive enable (low = released) |
| chain_dq_in | input | 1 | Feedback from the last device's cascade output |

## Verification
The feedback capture for bit k and the k-th CLK rise happen in the same cycle. The chain model in the bench shifts on that very rise, so a capture taken one cycle late would read the following bit. The test reads the chain from a known starting state and after each write. Each captured word is compared with the bit-reversed chain contents the bench predicts, and the committed contents are checked to be unchanged. A start request issued mid-operation, carrying another mode, word and divider, tests that the accepted operation's phase lengths and results stay intact.

// File: rtl/dcs_pkg.sv
package dcs_pkg;
  localparam int DEV_BITS = 17;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LO,
    ST_HI,
    ST_TAIL,
    ST_FIN
  } seq_state_t;
endpackage

// File: rtl/dcs_phase_timer.sv
module dcs_phase_timer #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [DIV_W-1:0] div_in,
  output logic             tick
);
  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      div_q <= '0;
      cnt   <= '0;
    end else if (load) begin
      div_q <= div_in;
      cnt   <= div_in;
    end else if (cnt == '0) begin
      cnt <= div_q;
    end else begin
      cnt <= cnt - DIV_W'(1);
    end
  end

  assign tick = (cnt == '0);
endmodule

// File: rtl/dcs_bit_buffers.sv
module dcs_bit_buffers #(
  parameter int TOT = 34
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           load,
  input  logic [TOT-1:0] wr_data,
  input  logic           shift,
  input  logic           cap,
  input  logic           dq_in,
  output logic           dq_out,
  output logic [TOT-1:0] rd_data
);
  logic [TOT-1:0] tx_q;
  logic [TOT-1:0] rx_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_q <= '0;
    end else if (load) begin
      tx_q <= wr_data;
    end else if (shift) begin
      tx_q <= {1'b0, tx_q[TOT-1:1]};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_q <= '0;
    end else if (cap) begin
      rx_q <= {dq_in, rx_q[TOT-1:1]};
    end
  end

  assign dq_out  = tx_q[0];
  assign rd_data = rx_q;
endmodule

// File: rtl/dcs_seq_fsm.sv
module dcs_seq_fsm
  import dcs_pkg::*;
#(
  parameter int TOT = 34
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic rd_mode,
  input  logic tick,
  output logic load,
  output logic shift,
  output logic cap,
  output logic busy,
  output logic done,
  output logic chain_rst,
  output logic chain_clk,
  output logic dq_oe
);
  localparam int CW = $clog2(TOT + 1);

  seq_state_t    st;
  logic [CW-1:0] nbits;
  logic          rd_q;

  assign load  = (st == ST_IDLE) && start;
  assign cap   = (st == ST_LO) && tick && rd_q;
  assign shift = (st == ST_HI) && tick;

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      nbits     <= '0;
      rd_q      <= 1'b0;
      busy      <= 1'b0;
      done      <= 1'b0;
      chain_rst <= 1'b0;
      chain_clk <= 1'b0;
      dq_oe     <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        ST_IDLE: if (start) begin
          rd_q      <= rd_mode;
          busy      <= 1'b1;
          chain_rst <= 1'b1;
          dq_oe     <= !rd_mode;
          nbits     <= '0;
          st        <= ST_LO;
        end
        ST_LO: if (tick) begin
          chain_clk <= 1'b1;
          st        <= ST_HI;
        end
        ST_HI: if (tick) begin
          chain_clk <= 1'b0;
          nbits     <= nbits + CW'(1);
          st        <= (nbits == CW'(TOT - 1)) ? ST_TAIL : ST_LO;
        end
        ST_TAIL: if (tick) begin
          chain_rst <= 1'b0;
          dq_oe     <= 1'b0;
          st        <= ST_FIN;
        end
        ST_FIN: begin
          done <= 1'b1;
          busy <= 1'b0;
          st   <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/chain_seq.sv
module chain_seq
  import dcs_pkg::*;
#(
  parameter int N_DEV = 2,
  parameter int DIV_W = 8
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      start,
  input  logic                      rd_mode,
  input  logic [DIV_W-1:0]          div_cfg,
  input  logic [N_DEV*DEV_BITS-1:0] wr_data,
  output logic [N_DEV*DEV_BITS-1:0] rd_data,
  output logic                      busy,
  output logic                      done,
  output logic                      chain_rst,
  output logic                      chain_clk,
  output logic                      chain_dq_out,
  output logic                      chain_dq_oe,
  input  logic                      chain_dq_in
);
  localparam int TOT = N_DEV * DEV_BITS;

  logic load;
  logic shift;
  logic cap;
  logic tick;

  dcs_phase_timer #(.DIV_W(DIV_W)) u_timer (
    .clk    (clk),
    .rst    (rst),
    .load   (load),
    .div_in (div_cfg),
    .tick   (tick)
  );

  dcs_seq_fsm #(.TOT(TOT)) u_fsm (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .rd_mode   (rd_mode),
    .tick      (tick),
    .load      (load),
    .shift     (shift),
    .cap       (cap),
    .busy      (busy),
    .done      (done),
    .chain_rst (chain_rst),
    .chain_clk (chain_clk),
    .dq_oe     (chain_dq_oe)
  );

  dcs_bit_buffers #(.TOT(TOT)) u_bufs (
    .clk     (clk),
    .rst     (rst),
    .load    (load),
    .wr_data (wr_data),
    .shift   (shift),
    .cap     (cap),
    .dq_in   (chain_dq_in),
    .dq_out  (chain_dq_out),
    .rd_data (rd_data)
  );
endmodule

// File: rtl/chain_seq_chk.sv
module chain_seq_chk (
  input logic clk,
  input logic rst,
  input logic busy,
  input logic done,
  input logic chain_rst,
  input logic chain_clk,
  input logic chain_dq_out
);
  // R1: the shift clock is high only inside the RST window
  a_r1_clk_in_window: assert property (@(posedge clk) disable iff (rst)
    chain_clk |-> chain_rst);

  // R2: RST edges happen with CLK low on both sides
  a_r2_rst_edge_clk_low: assert property (@(posedge clk) disable iff (rst)
    ($rose(chain_rst) || $fell(chain_rst)) |-> (!chain_clk && !$past(chain_clk)));

  // R3: DQ holds steady while CLK is high
  a_r3_dq_steady_high: assert property (@(posedge clk) disable iff (rst)
    chain_clk |-> $stable(chain_dq_out));

  // R7: done comes one cycle after RST falls
  a_r7_done_after_fall: assert property (@(posedge clk) disable iff (rst)
    done |-> (!chain_rst && !$past(chain_rst) && $past(chain_rst, 2)));

  // R7: done lasts a single cycle
  a_r7_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R7: busy covers the whole RST window
  a_r7_busy_covers: assert property (@(posedge clk) disable iff (rst)
    chain_rst |-> busy);
endmodule

bind chain_seq chain_seq_chk u_chk (
  .clk          (clk),
  .rst          (rst),
  .busy         (busy),
  .done         (done),
  .chain_rst    (chain_rst),
  .chain_clk    (chain_clk),
  .chain_dq_out (chain_dq_out)
);

// File: tb/chain_seq_tb.sv
module chain_seq_tb;
  localparam int N_DEV = 2;
  localparam int DIV_W = 8;
  localparam int TOT   = N_DEV * 17;

  typedef struct {
    bit             rd;
    logic [TOT-1:0] commit;
    logic [TOT-1:0] rdv;
    int             dv;
  } item_t;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             start = 1'b0;
  logic             rd_mode = 1'b0;
  logic [DIV_W-1:0] div_cfg = '0;
  logic [TOT-1:0]   wr_data = '0;
  logic [TOT-1:0]   rd_data;
  logic             busy, done, chain_rst, chain_clk, chain_dq_out, chain_dq_oe;
  logic             chain_dq_in;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  item_t          sb_q[$];
  logic [TOT-1:0] sreg;
  logic [TOT-1:0] committed;
  logic [TOT-1:0] exp_state;
  logic [TOT-1:0] exp_rd = '0;

  always #4 clk = ~clk;

  chain_seq #(.N_DEV(N_DEV), .DIV_W(DIV_W)) u_dut (
    .clk(clk), .rst(rst), .start(start), .rd_mode(rd_mode), .div_cfg(div_cfg),
    .wr_data(wr_data), .rd_data(rd_data), .busy(busy), .done(done),
    .chain_rst(chain_rst), .chain_clk(chain_clk), .chain_dq_out(chain_dq_out),
    .chain_dq_oe(chain_dq_oe), .chain_dq_in(chain_dq_in)
  );

  // chain model: one long shift register, output end at the top bit
  assign chain_dq_in = sreg[TOT-1];
  initial begin
    sreg      = 34'h2_A5C3_F0E1;
    committed = sreg;
    exp_state = sreg;
  end
  always @(posedge chain_clk)
    if (chain_rst) sreg <= {sreg[TOT-2:0], chain_dq_oe ? chain_dq_out : sreg[TOT-1]};
  always @(negedge chain_rst) committed = sreg;

  function automatic logic [TOT-1:0] rev(input logic [TOT-1:0] x);
    logic [TOT-1:0] r;
    for (int i = 0; i < TOT; i++) r[i] = x[TOT-1-i];
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor / scoreboard
  bit prev_rst = 0, prev_clk = 0, prev_done = 0, prev2_rst = 0;
  int run = 0, rises = 0, phase_bad = 0, oe_bad = 0, busy_bad = 0;
  always @(negedge clk) begin
    if (!rst) begin
      int edv;
      bit erd;
      edv = (sb_q.size() > 0) ? sb_q[0].dv : -1;
      erd = (sb_q.size() > 0) ? sb_q[0].rd : 1'b0;
      if ({chain_rst, chain_clk} != {prev_rst, prev_clk}) begin
        if (prev_rst && run != edv + 1) phase_bad++;
        run = 1;
      end else run++;
      if (chain_clk && !prev_clk) rises++;
      if (chain_clk && !chain_rst) phase_bad++;
      if (chain_rst && (chain_dq_oe == erd)) oe_bad++;
      if (chain_rst && !busy) busy_bad++;
      if (done) begin
        chk(!prev_done, "R7 done single pulse", prev_done, 0);
        chk(!prev_rst && prev2_rst, "R7 done follows RST fall", {prev2_rst, prev_rst}, 2'b10);
        chk(!busy, "R7 busy low with done", busy, 0);
        if (sb_q.size() == 0) chk(0, "R8 unexpected completion", 1, 0);
        else begin
          item_t it;
          it = sb_q.pop_front();
          chk(rises == TOT, "R1 rising edge count", rises, TOT);
          chk(phase_bad == 0, "R6 phase lengths", phase_bad, 0);
          chk(busy_bad == 0, "R7 busy during window", busy_bad, 0);
          if (it.rd) begin
            chk(oe_bad == 0, "R4 DQ released in read", oe_bad, 0);
            chk(rd_data == it.rdv, "R4 captured word", rd_data, it.rdv);
            chk(committed == it.commit, "R5 chain unchanged by read", committed, it.commit);
          end else begin
            chk(oe_bad == 0, "R3 DQ driven in write", oe_bad, 0);
            chk(committed == it.commit, "R3 written chain contents", committed, it.commit);
            chk(rd_data == it.rdv, "R9 write keeps rd_data", rd_data, it.rdv);
          end
        end
        rises = 0; phase_bad = 0; oe_bad = 0; busy_bad = 0;
      end
    end
    prev2_rst = prev_rst;
    prev_rst  = chain_rst;
    prev_clk  = chain_clk;
    prev_done = done;
  end

  // driver: predicts the result, queues it, then issues the request
  task automatic run_op(input bit rd, input logic [TOT-1:0] d, input int dv, input bit poke);
    item_t it;
    it.rd = rd;
    it.dv = dv;
    if (rd) begin
      it.commit = exp_state;
      exp_rd    = rev(exp_state);
      it.rdv    = exp_rd;
    end else begin
      exp_state = rev(d);
      it.commit = exp_state;
      it.rdv    = exp_rd;
    end
    sb_q.push_back(it);
    @(negedge clk);
    start = 1; rd_mode = rd; wr_data = d; div_cfg = DIV_W'(dv);
    @(negedge clk);
    start = 0;
    if (poke) begin
      repeat (7) @(negedge clk);
      start = 1; rd_mode = !rd; wr_data = ~d; div_cfg = DIV_W'(dv + 2);
      @(negedge clk);
      start = 0;
    end
    while (!done) @(negedge clk);
    repeat (3) @(negedge clk);
    if (poke) begin
      repeat (40) @(negedge clk);
      chk(!busy && !chain_rst && sb_q.size() == 0, "R8 no second operation",
          {busy, chain_rst}, 0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(!busy && !done && !chain_rst && !chain_clk && !chain_dq_oe, "R9 reset outputs",
        {busy, done, chain_rst, chain_clk, chain_dq_oe}, 0);
    chk(rd_data == '0, "R9 reset rd_data", rd_data, 0);
    run_op(1, '0, 0, 0);                 // read initial contents
    run_op(0, 34'h1_2345_6789, 1, 0);    // write
    run_op(1, '0, 3, 0);                 // read back
    run_op(0, 34'h3_0F0F_00FF, 0, 1);    // write with ignored start
    run_op(1, '0, 2, 1);                 // read with ignored start
    run_op(0, '1, 0, 0);                 // all ones
    run_op(1, '0, 0, 0);
    run_op(0, 34'h0_0000_0001, 4, 0);    // single bit
    run_op(1, '0, 1, 0);
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule